// File: doc/BRIEF.md
# Exception Vector and Nesting Unit

This unit sits beside the fetch stage. It takes the requests raised by the exception sources in the current cycle. These are a machine-check line, an external critical-interrupt line, a watchdog time-out line and a small set of base-class lines. The unit compares them with the enable bits of the current machine-state word and takes at most one of them. In the same cycle it raises a redirect and supplies the handler address, the exception number and the state word the pipeline loads next. At the clock edge of that cycle it records the interrupted PC and state word in the save/restore pair that belongs to the class of the taken exception.

The handler address has two halves. The upper half comes from a prefix register shared by all exceptions. The lower half comes from an offset register that each exception has for itself, and those offsets are always word-aligned. A compatibility input replaces the programmed offsets with a fixed layout, with 256-byte steps per exception. There are three nesting classes: machine check above critical, and critical above base. Each class has its own save pair and its own return strobe. A return strobe presents the saved PC and state word of its class so that the pipeline can resume.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset no redirect and no return are signalled while no input requests one, and every save pair reads back PC 0 and state 0.
- R2: For a taken exception, `target_o` is the shared prefix (written with `cfg_sel_i` = 0, upper half of `cfg_wdata_i` kept) in the upper half and the exception's offset in the lower half. The offset of exception n is written with `cfg_sel_i` = n+1.
- R3: Offsets hold word-aligned values: bits 1:0 of a written offset are stored as zero, so `target_o[1:0]` is always 0.
- R4: While `compat_i` is 1, the offset of exception n is the fixed value (n+2)*0x100 in place of the programmed one.
- R5: Exception numbers are: 0 machine check, 1 external critical, 2 watchdog, 3+k base line k. The eligible request with the lowest number is taken, and only one is taken per cycle.
- R6: The state-word enables are bit 12 for machine check, bit 17 for critical and bit 15 for base. A request whose class enable is 0 is not taken. If the request is still raised when the enable becomes 1, it is taken.
- R7: On a take, `state_o` is the incoming state word with the enable of the taken class and of every lower class cleared. All other bits are kept.
- R8: On a take, the class's save pair captures `pc_i` and `state_i`. The return strobe of that class (`ret_i` bit 0 base, bit 1 critical, bit 2 machine check) then shows them on `ret_pc_o` and `ret_state_o` with `ret_valid_o` = 1.
- R9: A critical exception is taken inside a base handler (base enable clear, critical enable set) and does not disturb the base save pair.
- R10: The external critical line and the watchdog line both belong to the critical class and save into the critical pair.
- R11: When several return strobes are raised, the highest class is returned. A return strobe raised in a cycle that takes an exception has no effect: `ret_valid_o` = 0.
- R12: Machine check uses its own save pair, separate from the critical and base pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for prefix/offset registers |
| cfg_sel_i | input | SELW (3) | 0 selects prefix, n+1 selects offset of exception n |
| cfg_wdata_i | input | AW (32) | Write data |
| compat_i | input | 1 | Fixed-offset compatibility mode |
| mchk_req_i | input | 1 | Machine-check request |
| crit_req_i | input | 1 | External critical-interrupt request |
| wdog_req_i | input | 1 | Watchdog time-out request |
| base_req_i | input | NB (4) | Base-class request lines |
| pc_i | input | AW (32) | PC of the interrupted instruction |
| state_i | input | SW (32) | Current machine-state word |
| ret_i | input | 3 | Return strobes per class |
| redirect_o | output | 1 | An exception is taken this cycle |
| target_o | output | AW (32) | Handler fetch address (0 when no redirect) |
| exc_id_o | output | IDW (3) | Number of the taken exception |
| state_o | output | SW (32) | State word to load on redirect (0 when no redirect) |
| ret_valid_o | output | 1 | A return is performed this cycle |
| ret_pc_o | output | AW (32) | Restored PC (0 when no return) |
| ret_state_o | output | SW (32) | Restored state word (0 when no return) |

## Verification
The assertions take for granted that the pipeline loads `state_o` in the cycle the redirect is raised. Because of this, a request never sees the stale enables of a cycle that has just taken one. They also take for granted that request and return inputs are stable between clock edges. The bench drives every input once per cycle, at the falling edge. It builds each state word itself, either with the enables the scenario needs or with the exact cleared word the unit returned, so the state words it presents follow real nesting.

// File: rtl/exc_pkg.sv
// Package: shared types for the exception vector and nesting unit.
// Assumes: three nesting classes, ordered by encoding (higher value = higher class).
package exc_pkg;
    typedef enum logic [1:0] {
        CLS_BASE = 2'd0,
        CLS_CRIT = 2'd1,
        CLS_MCHK = 2'd2
    } exc_class_e;

    localparam int NUM_CLS = 3;
    localparam int NUM_FIXED_SRC = 3;
endpackage

// File: rtl/exc_arbiter.sv
// Module: exc_arbiter
// Picks at most one exception per cycle among the eligible requests, in
// fixed priority: machine check, external critical, watchdog, then base lines
// with the lowest index first. A request is eligible only if its class
// enable bit in the state word is set.
// Assumes: request lines are levels held by their sources until serviced.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int NB     = 4,
    parameter int SW     = 32,
    parameter int IDW    = 3,
    parameter int EE_BIT = 15,
    parameter int CE_BIT = 17,
    parameter int ME_BIT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mchk_req_i,
    input  logic          crit_req_i,
    input  logic          wdog_req_i,
    input  logic [NB-1:0] base_req_i,
    input  logic [SW-1:0] state_i,
    output logic          take_o,
    output logic [IDW-1:0] id_o,
    output exc_class_e    cls_o
);

    // Fixed-priority selection of the single exception taken this cycle.
    always_comb begin
        take_o = 1'b0;
        id_o   = '0;
        cls_o  = CLS_BASE;
        if (mchk_req_i && state_i[ME_BIT]) begin
            take_o = 1'b1;
            id_o   = IDW'(0);
            cls_o  = CLS_MCHK;
        end else if (crit_req_i && state_i[CE_BIT]) begin
            take_o = 1'b1;
            id_o   = IDW'(1);
            cls_o  = CLS_CRIT;
        end else if (wdog_req_i && state_i[CE_BIT]) begin
            take_o = 1'b1;
            id_o   = IDW'(2);
            cls_o  = CLS_CRIT;
        end else if (state_i[EE_BIT]) begin
            for (int k = NB - 1; k >= 0; k--) begin
                if (base_req_i[k]) begin
                    take_o = 1'b1;
                    id_o   = IDW'(NUM_FIXED_SRC + k);
                    cls_o  = CLS_BASE;
                end
            end
        end
    end

    // R5
    mchk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_req_i && state_i[ME_BIT]) |-> (take_o && cls_o == CLS_MCHK));

    // R6
    base_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cls_o == CLS_BASE) |-> state_i[EE_BIT]);

    // R6
    crit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cls_o == CLS_CRIT) |-> state_i[CE_BIT]);

endmodule

// File: rtl/exc_vector_table.sv
// Module: exc_vector_table
// Holds the shared prefix (upper address half) and one word-aligned offset
// (lower address half) per exception, and forms the handler address for the
// selected exception. In compatibility mode a fixed 0x100-step offset layout
// is used in place of the programmed offsets.
// Assumes: AW is even; offsets of NEXC+2 entries at 0x100 steps fit in AW/2 bits.
module exc_vector_table #(
    parameter int AW   = 32,
    parameter int NEXC = 7,
    parameter int IDW  = 3,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic [SELW-1:0] cfg_sel_i,
    input  logic [AW-1:0]   cfg_wdata_i,
    input  logic            compat_i,
    input  logic [IDW-1:0]  id_i,
    output logic [AW-1:0]   target_o
);
    localparam int HW = AW / 2;

    logic [HW-1:0] prefix_q;
    logic [HW-1:0] off_q [NEXC];
    logic [HW-1:0] off_sel;
    logic          unused_low;

    assign unused_low = ^cfg_wdata_i[1:0];

    // Prefix register: keeps the upper half of the written word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prefix_q <= '0;
        else if (cfg_we_i && cfg_sel_i == '0)
            prefix_q <= cfg_wdata_i[AW-1:HW];
    end

    for (genvar g = 0; g < NEXC; g++) begin : g_off
        // Offset register of exception g, forced word-aligned on write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                off_q[g] <= '0;
            else if (cfg_we_i && cfg_sel_i == SELW'(g + 1))
                off_q[g] <= {cfg_wdata_i[HW-1:2], 2'b00};
        end
    end

    // Offset selection: fixed layout in compatibility mode, else programmed.
    always_comb begin
        if (compat_i)
            off_sel = HW'((int'(id_i) + 2) << 8);
        else if (int'(id_i) < NEXC)
            off_sel = off_q[id_i];
        else
            off_sel = '0;
    end

    assign target_o = {prefix_q, off_sel};

    // R3
    off_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        target_o[1:0] == 2'b00);

endmodule

// File: rtl/exc_save_pair.sv
// Module: exc_save_pair
// One save/restore register pair: captures the interrupted PC and state word
// when its class is taken, and holds them otherwise.
// Assumes: capture is asserted for at most one cycle per take.
module exc_save_pair #(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [AW-1:0] pc_i,
    input  logic [SW-1:0] state_i,
    output logic [AW-1:0] pc_o,
    output logic [SW-1:0] state_o
);
    // Capture context on take, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o    <= '0;
            state_o <= '0;
        end else if (cap_i) begin
            pc_o    <= pc_i;
            state_o <= state_i;
        end
    end

    // R8
    save_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (pc_o == $past(pc_i) && state_o == $past(state_i)));

    // R9
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(pc_o) && $stable(state_o)));

endmodule

// File: rtl/exc_vector_unit.sv
// Module: exc_vector_unit (top)
// Takes at most one exception per cycle, forms its handler address, supplies
// the masked state word, and saves the context into the pair of the taken
// class. Return strobes present the saved context of the highest strobed class.
// Assumes: the pipeline loads state_o in the redirect cycle; a return strobe
// coinciding with a take is dropped.
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SW     = 32,
    parameter int NB     = 4,
    parameter int EE_BIT = 15,
    parameter int CE_BIT = 17,
    parameter int ME_BIT = 12,
    localparam int NEXC  = NUM_FIXED_SRC + NB,
    localparam int IDW   = $clog2(NEXC),
    localparam int SELW  = $clog2(NEXC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic [SELW-1:0] cfg_sel_i,
    input  logic [AW-1:0]   cfg_wdata_i,
    input  logic            compat_i,
    input  logic            mchk_req_i,
    input  logic            crit_req_i,
    input  logic            wdog_req_i,
    input  logic [NB-1:0]   base_req_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [SW-1:0]   state_i,
    input  logic [2:0]      ret_i,
    output logic            redirect_o,
    output logic [AW-1:0]   target_o,
    output logic [IDW-1:0]  exc_id_o,
    output logic [SW-1:0]   state_o,
    output logic            ret_valid_o,
    output logic [AW-1:0]   ret_pc_o,
    output logic [SW-1:0]   ret_state_o
);
    logic           take;
    logic [IDW-1:0] take_id;
    exc_class_e     take_cls;
    logic [AW-1:0]  vec_addr;
    logic [AW-1:0]  sav_pc [NUM_CLS];
    logic [SW-1:0]  sav_st [NUM_CLS];
    logic [SW-1:0]  clr_mask;
    exc_class_e     ret_cls;

    exc_arbiter #(
        .NB(NB), .SW(SW), .IDW(IDW),
        .EE_BIT(EE_BIT), .CE_BIT(CE_BIT), .ME_BIT(ME_BIT)
    ) u_arb (
        .clk(clk), .rst_n(rst_n),
        .mchk_req_i(mchk_req_i), .crit_req_i(crit_req_i),
        .wdog_req_i(wdog_req_i), .base_req_i(base_req_i),
        .state_i(state_i),
        .take_o(take), .id_o(take_id), .cls_o(take_cls)
    );

    exc_vector_table #(
        .AW(AW), .NEXC(NEXC), .IDW(IDW), .SELW(SELW)
    ) u_vec (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .compat_i(compat_i), .id_i(take_id), .target_o(vec_addr)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_save
        exc_save_pair #(.AW(AW), .SW(SW)) u_pair (
            .clk(clk), .rst_n(rst_n),
            .cap_i(take && take_cls == exc_class_e'(c)),
            .pc_i(pc_i), .state_i(state_i),
            .pc_o(sav_pc[c]), .state_o(sav_st[c])
        );
    end

    // Enable bits cleared on take: the taken class and every class below it.
    always_comb begin
        clr_mask = '0;
        clr_mask[EE_BIT] = 1'b1;
        if (take_cls != CLS_BASE) clr_mask[CE_BIT] = 1'b1;
        if (take_cls == CLS_MCHK) clr_mask[ME_BIT] = 1'b1;
    end

    // Redirect outputs, zero when nothing is taken.
    always_comb begin
        redirect_o = take;
        target_o   = take ? vec_addr : '0;
        exc_id_o   = take ? take_id : '0;
        state_o    = take ? (state_i & ~clr_mask) : '0;
    end

    // Return selection: highest strobed class wins; dropped during a take.
    always_comb begin
        if (ret_i[2])      ret_cls = CLS_MCHK;
        else if (ret_i[1]) ret_cls = CLS_CRIT;
        else               ret_cls = CLS_BASE;
        ret_valid_o = (|ret_i) && !take;
        ret_pc_o    = ret_valid_o ? sav_pc[ret_cls] : '0;
        ret_state_o = ret_valid_o ? sav_st[ret_cls] : '0;
    end

    // R7
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (!state_o[EE_BIT] &&
                        (exc_id_o > IDW'(2) || !state_o[CE_BIT])));

    // R2
    prefix_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && $past(redirect_o) && !$past(cfg_we_i))
            |-> target_o[AW-1:AW/2] == $past(target_o[AW-1:AW/2]));

    // R11
    ret_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !ret_valid_o);

endmodule

// File: tb/tb_exc_vector_unit.sv
// Bench: scoreboard for exc_vector_unit. A driver task applies one cycle of
// stimulus at the falling edge and pushes the expected outputs, computed from
// a reference model of the requirements; a monitor pops and compares them a
// quarter period later.
module tb_exc_vector_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 32;
    localparam int NB = 4;
    localparam int NEXC = 7;
    localparam int EE = 15;
    localparam int CE = 17;
    localparam int ME = 12;
    localparam logic [31:0] ALL_EN = 32'h0002_9003;

    typedef struct packed {
        logic        redir;
        logic [31:0] tgt;
        logic [2:0]  id;
        logic [31:0] st;
        logic        rv;
        logic [31:0] rpc;
        logic [31:0] rst;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic compat = 1'b0;
    logic mchk = 1'b0, crit = 1'b0, wdog = 1'b0;
    logic [NB-1:0] base = '0;
    logic [31:0] pc = '0, st = '0;
    logic [2:0] ret = '0;
    logic redirect_o, ret_valid_o;
    logic [31:0] target_o, state_o, ret_pc_o, ret_state_o;
    logic [2:0] exc_id_o;

    exp_t  exp_q[$];
    string tag_q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [15:0] m_prefix = '0;
    logic [15:0] m_off [NEXC];
    logic        m_compat = 1'b0;
    logic [31:0] m_spc [3];
    logic [31:0] m_sst [3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_vector_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .compat_i(compat),
        .mchk_req_i(mchk), .crit_req_i(crit), .wdog_req_i(wdog),
        .base_req_i(base), .pc_i(pc), .state_i(st), .ret_i(ret),
        .redirect_o(redirect_o), .target_o(target_o), .exc_id_o(exc_id_o),
        .state_o(state_o), .ret_valid_o(ret_valid_o),
        .ret_pc_o(ret_pc_o), .ret_state_o(ret_state_o)
    );

    // Driver for one request cycle: model expectation, push, drive.
    task automatic step(input logic i_m, input logic i_c, input logic i_w,
                        input logic [NB-1:0] i_b, input logic [31:0] i_pc,
                        input logic [31:0] i_st, input logic [2:0] i_ret,
                        input string tag);
        exp_t e;
        int cls;
        int id;
        logic [15:0] off;
        e = '0;
        id = -1;
        cls = 0;
        if (i_m && i_st[ME]) begin id = 0; cls = 2; end
        else if (i_c && i_st[CE]) begin id = 1; cls = 1; end
        else if (i_w && i_st[CE]) begin id = 2; cls = 1; end
        else if (i_st[EE]) begin
            for (int k = 0; k < NB; k++)
                if (i_b[k] && id < 0) begin id = 3 + k; cls = 0; end
        end
        if (id >= 0) begin
            off = m_compat ? 16'((id + 2) * 256) : m_off[id];
            e.redir = 1'b1;
            e.tgt = {m_prefix, off};
            e.id = 3'(id);
            e.st = i_st;
            e.st[EE] = 1'b0;
            if (cls >= 1) e.st[CE] = 1'b0;
            if (cls == 2) e.st[ME] = 1'b0;
        end else if (i_ret != 3'b000) begin
            int rc;
            rc = i_ret[2] ? 2 : (i_ret[1] ? 1 : 0);
            e.rv = 1'b1;
            e.rpc = m_spc[rc];
            e.rst = m_sst[rc];
        end
        @(negedge clk);
        cfg_we = 1'b0;
        mchk = i_m; crit = i_c; wdog = i_w; base = i_b;
        pc = i_pc; st = i_st; ret = i_ret;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (id >= 0) begin
            m_spc[cls] = i_pc;
            m_sst[cls] = i_st;
        end
    endtask

    // Driver for a configuration write cycle (no comparison).
    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        mchk = 1'b0; crit = 1'b0; wdog = 1'b0; base = '0; ret = '0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (sel == 3'd0) m_prefix = data[31:16];
        else m_off[sel - 1] = {data[15:2], 2'b00};
    endtask

    task automatic set_compat(input logic v);
        @(negedge clk);
        cfg_we = 1'b0; mchk = 1'b0; crit = 1'b0; wdog = 1'b0; base = '0; ret = '0;
        compat = v;
        m_compat = v;
    endtask

    // Monitor: pop and compare expected outputs a quarter period after drive.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            if (exp_q.size() > 0) begin
                exp_t e;
                exp_t a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.redir = redirect_o; a.tgt = target_o; a.id = exc_id_o;
                a.st = state_o; a.rv = ret_valid_o;
                a.rpc = ret_pc_o; a.rst = ret_state_o;
                compared++;
                if (a !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual redir=%b tgt=%h id=%0d st=%h rv=%b rpc=%h rst=%h expected redir=%b tgt=%h id=%0d st=%h rv=%b rpc=%h rst=%h",
                             t, a.redir, a.tgt, a.id, a.st, a.rv, a.rpc, a.rst,
                             e.redir, e.tgt, e.id, e.st, e.rv, e.rpc, e.rst);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        for (int i = 0; i < NEXC; i++) m_off[i] = '0;
        for (int i = 0; i < 3; i++) begin m_spc[i] = '0; m_sst[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, and save pairs read zero
        step(0, 0, 0, 4'b0000, 32'h0, ALL_EN, 3'b000, "R1 idle");
        step(0, 0, 0, 4'b0000, 32'h0, ALL_EN, 3'b001, "R1 base pair zero");
        step(0, 0, 0, 4'b0000, 32'h0, ALL_EN, 3'b100, "R1 mchk pair zero");

        // R2/R3: program prefix and offsets with low bits set
        cfg_write(3'd0, 32'hABCD_1234);
        for (int k = 0; k < NEXC; k++)
            cfg_write(3'(k + 1), 32'h0000_1003 + 32'(k * 64));
        step(0, 0, 0, 4'b0001, 32'h100, ALL_EN, 3'b000, "R2 base0 vector");
        step(0, 1, 0, 4'b0000, 32'h104, ALL_EN, 3'b000, "R3 crit aligned offset");

        // R5: priority ordering
        step(1, 1, 1, 4'b1111, 32'h200, ALL_EN, 3'b000, "R5 mchk wins");
        step(0, 1, 1, 4'b1111, 32'h204, ALL_EN, 3'b000, "R5 ext crit over wdog");
        step(0, 0, 1, 4'b1111, 32'h208, ALL_EN, 3'b000, "R5 wdog over base");
        step(0, 0, 0, 4'b1010, 32'h20C, ALL_EN, 3'b000, "R5 lowest base line");

        // R6: gating and pending requests
        step(0, 0, 0, 4'b0100, 32'h300, ALL_EN & ~(32'h1 << EE), 3'b000, "R6 base gated");
        step(0, 0, 0, 4'b0100, 32'h304, ALL_EN, 3'b000, "R6 pending base taken");
        step(0, 1, 1, 4'b0000, 32'h308, ALL_EN & ~(32'h1 << CE), 3'b000, "R6 crit gated");
        step(1, 0, 0, 4'b0000, 32'h30C, ALL_EN & ~(32'h1 << ME), 3'b000, "R6 mchk gated");

        // R7: masking keeps other bits
        step(0, 0, 0, 4'b1000, 32'h400, 32'hFFFF_FFFF, 3'b000, "R7 base clears only base");
        step(0, 1, 0, 4'b0000, 32'h404, 32'hFFFF_FFFF, 3'b000, "R7 crit clears crit and base");
        step(1, 0, 0, 4'b0000, 32'h408, 32'hFFFF_FFFF, 3'b000, "R7 mchk clears all three");

        // R4: compatibility offsets
        set_compat(1'b1);
        step(0, 0, 1, 4'b0000, 32'h500, ALL_EN, 3'b000, "R4 compat wdog");
        step(0, 0, 0, 4'b1000, 32'h504, ALL_EN, 3'b000, "R4 compat base3");
        set_compat(1'b0);

        // R8/R9: base handler nested by critical, returns unwind in order
        step(0, 0, 0, 4'b0100, 32'h2000, ALL_EN, 3'b000, "R8 base take");
        step(0, 1, 0, 4'b0000, 32'h2004, ALL_EN & ~(32'h1 << EE), 3'b000, "R9 crit nests in base");
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b010, "R8 crit return");
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b001, "R9 base pair intact");

        // R10: watchdog saves into critical pair
        step(0, 0, 1, 4'b0000, 32'h3000, ALL_EN, 3'b000, "R10 wdog take");
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b010, "R10 crit pair from wdog");

        // R12: machine check pair separate
        step(1, 0, 0, 4'b0000, 32'h4000, 32'h0000_1000, 3'b000, "R12 mchk take");
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b100, "R12 mchk return");
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b010, "R12 crit pair untouched");

        // R11: return priority and drop during a take
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b111, "R11 highest return wins");
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b011, "R11 crit over base return");
        step(0, 0, 0, 4'b0001, 32'h5000, ALL_EN, 3'b111, "R11 return dropped on take");
        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b001, "R11 base pair from take");

        step(0, 0, 0, 4'b0000, 32'h0, 32'h0, 3'b000, "R1 quiet end");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule